// File: doc/BRIEF.md
# Tamper-Response and Security-Lock Controller

This block owns the security state of a protected processor: a lock bit, a key register of `KEY_BYTES` bytes, and the sequence that destroys secrets when the lock is released. It receives an active-high tamper pin, which it synchronizes and deglitches. It also receives an active-low loader-request pin. It turns that pin into a clean loader-mode flag only after the pin has held one level for a programmable number of clocks. The command decoder of the loader passes three one-cycle command strobes: release the lock, engage the lock, and request a session key. The block acts on them only while loader mode is active.

A qualified tamper event or an accepted release command starts an erase sequence that nothing can stop. On the start edge, the key is zeroed and marked invalid and the lock drops. The block then walks every entry of a small vector RAM with a write strobe, and then walks the lower region of external memory, writing zero to one address per cycle. At the end it loads a fresh key from the random-byte input and raises a done flag. A tamper event also pulses a power-kill output for the external bus for a fixed number of cycles.

Session keys are drawn once per loader session. The first key request of a session, or the key load that closes an erase, fixes the key until loader mode is left. A loader that reads back or verifies therefore sees a consistent key.

Top module: `tamper_lock_ctrl`

## Requirements
- R1: After reset the lock is clear, the key is all zero and invalid, loader mode is off, the done flag is low and no erase, permit or power-kill output is active.
- R2: The tamper pin starts clearing only once it has been seen high on `SDI_ACC_CYC` consecutive clock edges. A shorter high pulse (`SDI_ACC_CYC`-1 edges or less) has no effect on key, lock or power-kill. The first erase strobe appears after the edge `SDI_ACC_CYC`+2 counted from the first edge at which the pin is high.
- R3: Loader mode turns on at the edge `QUAL_CYC`+2 after the request pin is first sampled low, and not one edge earlier. It turns off with the same latency after the pin returns high.
- R4: On the edge that starts clearing, the key becomes zero, key-valid drops and the lock drops.
- R5: Clearing first writes every vector RAM entry, addresses 0 to `VEC_DEPTH`-1 in rising order, one per cycle, starting in the cycle right after the start edge.
- R6: Directly after the vector walk, external addresses 0 to `FILL_DEPTH`-1 are written in rising order, one per cycle, with write data zero.
- R7: In the cycle after the last fill write, the key is loaded from the random input, key-valid and the done flag rise and the busy flag falls. The done flag falls again when a new clearing starts.
- R8: While clearing is under way, the command strobes and the tamper pin have no effect: the lock stays clear, the key stays invalid, no power-kill pulse occurs and the walks are not restarted.
- R9: A key request in loader mode, with the lock clear and no erase running, loads the random input only if no key has been fixed in the current session. Later requests keep that key. The key loaded at the end of an erase also fixes the session key. Leaving loader mode ends the session.
- R10: The engage command in loader mode sets the lock. While the lock is set, key requests leave the key unchanged.
- R11: External-memory access is permitted exactly while loader mode is on, the lock is clear and no erase is running.
- R12: A tamper start raises the power-kill output for exactly `KILL_CYC` cycles, beginning with the start edge. A release command never raises it.
- R13: A tamper event wins over any command strobe in the same cycle: an engage command in that cycle leaves the lock clear.
- R14: Outside loader mode all three command strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Tamper pin, active high, asynchronous |
| prog_n_i | input | 1 | Loader-request pin, active low, asynchronous |
| cmd_clr_i | input | 1 | Release-lock command strobe |
| cmd_set_i | input | 1 | Engage-lock command strobe |
| cmd_rekey_i | input | 1 | Session-key request strobe |
| rnd_i | input | KEY_BYTES*8 | Random bytes from the entropy source |
| key_o | output | KEY_BYTES*8 | Current key for the encryptors |
| key_valid_o | output | 1 | Key register holds a usable key |
| lock_o | output | 1 | Security lock state |
| loader_o | output | 1 | Qualified loader mode |
| sram_permit_o | output | 1 | External memory access allowed for the loader |
| erase_busy_o | output | 1 | Erase sequence running |
| erase_done_o | output | 1 | Last erase ran to completion |
| vec_wr_o | output | 1 | Vector RAM clear strobe |
| vec_addr_o | output | clog2(VEC_DEPTH) | Vector RAM address being cleared |
| ext_wr_o | output | 1 | External memory zero-fill strobe |
| ext_addr_o | output | clog2(FILL_DEPTH) | External address being filled |
| ext_wdata_o | output | DATA_W | Fill data (zero) |
| bus_kill_o | output | 1 | Power-kill pulse for the external bus |

## Verification
Each result has a fixed latency. Command effects on key and lock appear after the edge that samples the strobe. Loader mode follows `QUAL_CYC`+2 edges after a pin change. A tamper start follows `SDI_ACC_CYC`+2 edges after the pin rises. Then come the vector walk, the fill walk and the key load, in that order. The bench drives strobes for one cycle and checks the flags on the following falling edge, or at exactly the predicted threshold edge and one edge before it. A scoreboard queue is filled with every expected vector and fill write when a clearing is triggered. A monitor pops one entry per observed strobe, so a missing, reordered, extra or restarted walk shows up as a mismatch.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

   typedef enum logic [1:0] {
      ER_IDLE = 2'd0,
      ER_VEC  = 2'd1,
      ER_FILL = 2'd2,
      ER_KEY  = 2'd3
   } er_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("tlc_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] ff_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[0] <= RST_VAL;
            else        ff_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[g] <= RST_VAL;
            else        ff_q[g] <= ff_q[g-1];
         end
      end
   end

   assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tlc_deglitch.sv
module tlc_deglitch #(
   parameter int SYNC_STAGES = 2,
   parameter int REJ_CYC     = 260,
   parameter int ACC_CYC     = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic fire_o
);
   localparam int CW = $clog2(ACC_CYC + 1);
   localparam logic [CW-1:0] SAT_V  = CW'(ACC_CYC);
   localparam logic [CW-1:0] FIRE_V = CW'(ACC_CYC - 1);

   if (ACC_CYC <= REJ_CYC) begin : g_bad_window
      $error("tlc_deglitch: accept count must exceed reject count");
   end
   if (REJ_CYC < 1) begin : g_bad_rej
      $error("tlc_deglitch: reject count must be positive");
   end

   logic          pin_s;
   logic [CW-1:0] run_q;

   tlc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              run_q <= '0;
      else if (!pin_s)         run_q <= '0;
      else if (run_q != SAT_V) run_q <= run_q + CW'(1);
   end

   assign fire_o = pin_s && (run_q == FIRE_V);
endmodule

// File: rtl/tlc_qualify.sv
module tlc_qualify #(
   parameter int   SYNC_STAGES = 2,
   parameter int   HOLD_CYC    = 48,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic active_o
);
   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] LAST_V = HW'(HOLD_CYC - 1);

   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("tlc_qualify: hold count must be at least 2");
   end

   logic          pin_s;
   logic          want;
   logic          act_q;
   logic [HW-1:0] hold_q;

   tlc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   assign want = (pin_s != IDLE_LEVEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hold_q <= '0;
      end else if (want == act_q) begin
         hold_q <= '0;
      end else if (hold_q == LAST_V) begin
         act_q  <= want;
         hold_q <= '0;
      end else begin
         hold_q <= hold_q + HW'(1);
      end
   end

   assign active_o = act_q;
endmodule

// File: rtl/tlc_erase_seq.sv
module tlc_erase_seq
   import tlc_pkg::*;
#(
   parameter int VEC_DEPTH  = 48,
   parameter int FILL_DEPTH = 32768,
   parameter int KILL_CYC   = 16,
   localparam int VEC_AW  = $clog2(VEC_DEPTH),
   localparam int FILL_AW = $clog2(FILL_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               kill_i,
   output logic               busy_o,
   output logic               vec_wr_o,
   output logic [VEC_AW-1:0]  vec_addr_o,
   output logic               ext_wr_o,
   output logic [FILL_AW-1:0] ext_addr_o,
   output logic               reload_o,
   output logic               kill_o
);
   localparam int IW = max_int(VEC_AW, FILL_AW);
   localparam logic [IW-1:0] VEC_LAST  = IW'(VEC_DEPTH - 1);
   localparam logic [IW-1:0] FILL_LAST = IW'(FILL_DEPTH - 1);

   if (VEC_DEPTH < 2) begin : g_bad_vec
      $error("tlc_erase_seq: vector depth must be at least 2");
   end
   if ((FILL_DEPTH < 2) || ((FILL_DEPTH & (FILL_DEPTH - 1)) != 0)) begin : g_bad_fill
      $error("tlc_erase_seq: fill depth must be a power of two");
   end

   er_state_e     st_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ER_IDLE;
         idx_q <= '0;
      end else begin
         unique case (st_q)
            ER_IDLE: begin
               if (start_i) begin
                  st_q  <= ER_VEC;
                  idx_q <= '0;
               end
            end
            ER_VEC: begin
               if (idx_q == VEC_LAST) begin
                  st_q  <= ER_FILL;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            ER_FILL: begin
               if (idx_q == FILL_LAST) begin
                  st_q  <= ER_KEY;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            ER_KEY: begin
               st_q <= ER_IDLE;
            end
            default: st_q <= ER_IDLE;
         endcase
      end
   end

   assign busy_o     = (st_q != ER_IDLE);
   assign vec_wr_o   = (st_q == ER_VEC);
   assign ext_wr_o   = (st_q == ER_FILL);
   assign reload_o   = (st_q == ER_KEY);
   assign vec_addr_o = idx_q[VEC_AW-1:0];
   assign ext_addr_o = idx_q[FILL_AW-1:0];

   if (KILL_CYC > 0) begin : g_kill
      localparam int KW = $clog2(KILL_CYC + 1);
      logic [KW-1:0] kcnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               kcnt_q <= '0;
         else if (start_i && kill_i && !busy_o)    kcnt_q <= KW'(KILL_CYC);
         else if (kcnt_q != '0)                    kcnt_q <= kcnt_q - KW'(1);
      end
      assign kill_o = (kcnt_q != '0);
   end else begin : g_nokill
      assign kill_o = 1'b0;
   end
endmodule

// File: rtl/tamper_lock_ctrl.sv
module tamper_lock_ctrl #(
   parameter int KEY_BYTES   = 8,
   parameter int VEC_DEPTH   = 48,
   parameter int FILL_DEPTH  = 32768,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SDI_REJ_CYC = 260,
   parameter int SDI_ACC_CYC = 800,
   parameter int QUAL_CYC    = 48,
   parameter int KILL_CYC    = 16,
   localparam int KEY_W   = KEY_BYTES * 8,
   localparam int VEC_AW  = $clog2(VEC_DEPTH),
   localparam int FILL_AW = $clog2(FILL_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sdi_i,
   input  logic               prog_n_i,
   input  logic               cmd_clr_i,
   input  logic               cmd_set_i,
   input  logic               cmd_rekey_i,
   input  logic [KEY_W-1:0]   rnd_i,
   output logic [KEY_W-1:0]   key_o,
   output logic               key_valid_o,
   output logic               lock_o,
   output logic               loader_o,
   output logic               sram_permit_o,
   output logic               erase_busy_o,
   output logic               erase_done_o,
   output logic               vec_wr_o,
   output logic [VEC_AW-1:0]  vec_addr_o,
   output logic               ext_wr_o,
   output logic [FILL_AW-1:0] ext_addr_o,
   output logic [DATA_W-1:0]  ext_wdata_o,
   output logic               bus_kill_o
);
   if (KEY_BYTES < 1) begin : g_bad_key
      $error("tamper_lock_ctrl: key must have at least one byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tamper_lock_ctrl: at least two synchronizer stages required");
   end

   logic tamper;
   logic loader;
   logic busy;
   logic reload;
   logic start;
   logic set_ok;
   logic rekey_ok;

   logic [KEY_W-1:0] key_q;
   logic             kv_q;
   logic             lock_q;
   logic             done_q;
   logic             sess_q;

   tlc_deglitch #(
      .SYNC_STAGES (SYNC_STAGES),
      .REJ_CYC     (SDI_REJ_CYC),
      .ACC_CYC     (SDI_ACC_CYC)
   ) u_deglitch (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (sdi_i),
      .fire_o (tamper)
   );

   tlc_qualify #(
      .SYNC_STAGES (SYNC_STAGES),
      .HOLD_CYC    (QUAL_CYC),
      .IDLE_LEVEL  (1'b1)
   ) u_qualify (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (prog_n_i),
      .active_o (loader)
   );

   assign start    = !busy && (tamper || (loader && cmd_clr_i));
   assign set_ok   = loader && !busy && !tamper && cmd_set_i;
   assign rekey_ok = loader && !busy && !tamper && !lock_q && !sess_q && cmd_rekey_i;

   tlc_erase_seq #(
      .VEC_DEPTH  (VEC_DEPTH),
      .FILL_DEPTH (FILL_DEPTH),
      .KILL_CYC   (KILL_CYC)
   ) u_erase (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .kill_i     (tamper),
      .busy_o     (busy),
      .vec_wr_o   (vec_wr_o),
      .vec_addr_o (vec_addr_o),
      .ext_wr_o   (ext_wr_o),
      .ext_addr_o (ext_addr_o),
      .reload_o   (reload),
      .kill_o     (bus_kill_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         kv_q  <= 1'b0;
      end else if (start) begin
         key_q <= '0;
         kv_q  <= 1'b0;
      end else if (reload || rekey_ok) begin
         key_q <= rnd_i;
         kv_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= 1'b0;
      else if (start)  lock_q <= 1'b0;
      else if (set_ok) lock_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      done_q <= 1'b0;
      else if (start)  done_q <= 1'b0;
      else if (reload) done_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  sess_q <= 1'b0;
      else if (!loader)            sess_q <= 1'b0;
      else if (reload || rekey_ok) sess_q <= 1'b1;
   end

   assign key_o         = key_q;
   assign key_valid_o   = kv_q;
   assign lock_o        = lock_q;
   assign loader_o      = loader;
   assign erase_busy_o  = busy;
   assign erase_done_o  = done_q;
   assign sram_permit_o = loader && !lock_q && !busy;
   assign ext_wdata_o   = '0;
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
   parameter int KEY_W      = 64,
   parameter int VEC_AW     = 6,
   parameter int FILL_AW    = 15,
   parameter int FILL_DEPTH = 32768,
   parameter int DATA_W     = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [KEY_W-1:0]   key_o,
   input logic               key_valid_o,
   input logic               lock_o,
   input logic               loader_o,
   input logic               sram_permit_o,
   input logic               erase_busy_o,
   input logic               vec_wr_o,
   input logic [VEC_AW-1:0]  vec_addr_o,
   input logic               ext_wr_o,
   input logic [FILL_AW-1:0] ext_addr_o,
   input logic [DATA_W-1:0]  ext_wdata_o,
   input logic               bus_kill_o
);
   localparam logic [FILL_AW-1:0] FILL_LAST = FILL_AW'(FILL_DEPTH - 1);

   // R5
   walk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vec_wr_o && ext_wr_o));

   // R4
   erase_nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_wr_o || ext_wr_o) |-> (!key_valid_o && !lock_o));

   // R6
   fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr_o && (ext_addr_o != FILL_LAST)) |=>
         (ext_wr_o && (ext_addr_o == $past(ext_addr_o) + FILL_AW'(1))));

   // R6
   fill_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_wr_o) |-> ((ext_addr_o == '0) && $past(vec_wr_o) && (ext_wdata_o == '0)));

   // R5
   vec_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_wr_o) |-> (vec_addr_o == '0));

   // R11
   permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sram_permit_o |-> (loader_o && !lock_o && !erase_busy_o));

   // R10
   lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && $past(lock_o)) |-> $stable(key_o));

   // R12
   kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_kill_o) |-> (!key_valid_o && erase_busy_o));
endmodule

bind tamper_lock_ctrl tlc_chk #(
   .KEY_W      (KEY_W),
   .VEC_AW     (VEC_AW),
   .FILL_AW    (FILL_AW),
   .FILL_DEPTH (FILL_DEPTH),
   .DATA_W     (DATA_W)
) u_tlc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .key_o         (key_o),
   .key_valid_o   (key_valid_o),
   .lock_o        (lock_o),
   .loader_o      (loader_o),
   .sram_permit_o (sram_permit_o),
   .erase_busy_o  (erase_busy_o),
   .vec_wr_o      (vec_wr_o),
   .vec_addr_o    (vec_addr_o),
   .ext_wr_o      (ext_wr_o),
   .ext_addr_o    (ext_addr_o),
   .ext_wdata_o   (ext_wdata_o),
   .bus_kill_o    (bus_kill_o)
);

// File: tb/tamper_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module tamper_lock_ctrl_tb_top;
   localparam int KEY_BYTES = 8;
   localparam int VEC_DEPTH = 48;
   localparam int FILL      = 256;
   localparam int ACC       = 12;
   localparam int REJ       = 5;
   localparam int QUAL      = 48;
   localparam int KILL      = 4;
   localparam int KEY_W     = KEY_BYTES * 8;
   localparam int VEC_AW    = $clog2(VEC_DEPTH);
   localparam int FILL_AW   = $clog2(FILL);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic               rst_n;
   logic               sdi_i, prog_n_i, cmd_clr_i, cmd_set_i, cmd_rekey_i;
   logic [KEY_W-1:0]   rnd_i;
   logic [KEY_W-1:0]   key_o;
   logic               key_valid_o, lock_o, loader_o, sram_permit_o;
   logic               erase_busy_o, erase_done_o, vec_wr_o, ext_wr_o, bus_kill_o;
   logic [VEC_AW-1:0]  vec_addr_o;
   logic [FILL_AW-1:0] ext_addr_o;
   logic [7:0]         ext_wdata_o;

   tamper_lock_ctrl #(
      .KEY_BYTES(KEY_BYTES), .VEC_DEPTH(VEC_DEPTH), .FILL_DEPTH(FILL), .DATA_W(8),
      .SYNC_STAGES(2), .SDI_REJ_CYC(REJ), .SDI_ACC_CYC(ACC), .QUAL_CYC(QUAL),
      .KILL_CYC(KILL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .sdi_i(sdi_i), .prog_n_i(prog_n_i),
      .cmd_clr_i(cmd_clr_i), .cmd_set_i(cmd_set_i), .cmd_rekey_i(cmd_rekey_i),
      .rnd_i(rnd_i), .key_o(key_o), .key_valid_o(key_valid_o), .lock_o(lock_o),
      .loader_o(loader_o), .sram_permit_o(sram_permit_o), .erase_busy_o(erase_busy_o),
      .erase_done_o(erase_done_o), .vec_wr_o(vec_wr_o), .vec_addr_o(vec_addr_o),
      .ext_wr_o(ext_wr_o), .ext_addr_o(ext_addr_o), .ext_wdata_o(ext_wdata_o),
      .bus_kill_o(bus_kill_o)
   );

   typedef struct packed {
      logic        ext;
      logic [15:0] addr;
   } item_t;

   item_t exp_q[$];
   int    n_chk = 0;
   int    n_err = 0;
   int    kill_cnt = 0;
   bit    finished = 0;

   localparam logic [63:0] KA = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] KB = 64'hFEDC_BA98_7654_3210;
   localparam logic [63:0] KC = 64'h5A5A_0F0F_C3C3_9696;
   localparam logic [63:0] KD = 64'h1122_3344_5566_7788;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_erase();
      for (int i = 0; i < VEC_DEPTH; i++) exp_q.push_back('{ext: 1'b0, addr: 16'(i)});
      for (int i = 0; i < FILL; i++)      exp_q.push_back('{ext: 1'b1, addr: 16'(i)});
   endtask

   task automatic wait_done(input string tag);
      for (int i = 0; i < 2000 && !erase_done_o; i++) @(negedge clk);
      chk(erase_done_o && !erase_busy_o, tag, {62'd0, erase_busy_o, erase_done_o}, 64'd1);
   endtask

   // scoreboard monitor, sampling 1 ns after each rising edge
   always begin : mon
      item_t got;
      item_t e;
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (bus_kill_o) kill_cnt++;
         if (vec_wr_o || ext_wr_o) begin
            got.ext  = ext_wr_o;
            got.addr = ext_wr_o ? 16'(ext_addr_o) : 16'(vec_addr_o);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 erase write not expected", {47'd0, got}, 64'd0);
            end else begin
               e = exp_q.pop_front();
               if (e.ext) chk(got == e && ext_wdata_o == 8'd0, "R6 fill walk",
                              {39'd0, ext_wdata_o, got}, {47'd0, e});
               else       chk(got == e, "R5 vector clear walk", {47'd0, got}, {47'd0, e});
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin : drive
      rst_n = 1'b0; sdi_i = 1'b0; prog_n_i = 1'b1;
      cmd_clr_i = 1'b0; cmd_set_i = 1'b0; cmd_rekey_i = 1'b0; rnd_i = KA;
      tick(5);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(!lock_o && !key_valid_o && key_o == 0 && !loader_o && !erase_done_o,
          "R1 reset flags", {59'd0, lock_o, key_valid_o, (key_o != 0), loader_o, erase_done_o}, 0);
      chk(!sram_permit_o && !erase_busy_o && !vec_wr_o && !ext_wr_o && !bus_kill_o,
          "R1 reset strobes", {59'd0, sram_permit_o, erase_busy_o, vec_wr_o, ext_wr_o, bus_kill_o}, 0);

      // R14 commands outside loader mode
      cmd_set_i = 1'b1; cmd_rekey_i = 1'b1; cmd_clr_i = 1'b1;
      tick(1);
      cmd_set_i = 1'b0; cmd_rekey_i = 1'b0; cmd_clr_i = 1'b0;
      tick(1);
      chk(!lock_o && !key_valid_o && !erase_busy_o, "R14 commands outside loader",
          {61'd0, lock_o, key_valid_o, erase_busy_o}, 0);

      // R3 loader entry latency
      prog_n_i = 1'b0;
      tick(QUAL + 1);
      chk(!loader_o, "R3 loader not yet active", {63'd0, loader_o}, 0);
      tick(1);
      chk(loader_o, "R3 loader active", {63'd0, loader_o}, 1);
      chk(sram_permit_o, "R11 permit in open loader", {63'd0, sram_permit_o}, 1);

      // R9 first key request draws, second keeps
      cmd_rekey_i = 1'b1; tick(1); cmd_rekey_i = 1'b0; tick(1);
      chk(key_o == KA && key_valid_o, "R9 session key drawn", key_o, KA);
      rnd_i = KB;
      cmd_rekey_i = 1'b1; tick(1); cmd_rekey_i = 1'b0; tick(1);
      chk(key_o == KA, "R9 repeat request keeps key", key_o, KA);

      // R10 engage lock
      cmd_set_i = 1'b1; tick(1); cmd_set_i = 1'b0; tick(1);
      chk(lock_o, "R10 lock engaged", {63'd0, lock_o}, 1);
      chk(!sram_permit_o, "R11 permit denied under lock", {63'd0, sram_permit_o}, 0);
      cmd_rekey_i = 1'b1; tick(1); cmd_rekey_i = 1'b0; tick(1);
      chk(key_o == KA, "R10 key request under lock", key_o, KA);

      // R4 release command starts clearing
      kill_cnt = 0;
      push_erase();
      cmd_clr_i = 1'b1; tick(1); cmd_clr_i = 1'b0;
      chk(key_o == 0 && !key_valid_o && !lock_o, "R4 release clears key and lock",
          {62'd0, key_valid_o, lock_o} | key_o, 0);
      chk(vec_wr_o && vec_addr_o == 0, "R5 vector walk starts next cycle",
          {56'd0, vec_wr_o, 1'b0, vec_addr_o}, 64'h80);
      chk(!bus_kill_o, "R12 release gives no power kill", {63'd0, bus_kill_o}, 0);
      chk(!erase_done_o, "R7 done cleared at start", {63'd0, erase_done_o}, 0);

      // R8 commands during clearing
      tick(20);
      cmd_set_i = 1'b1; cmd_rekey_i = 1'b1; cmd_clr_i = 1'b1;
      tick(1);
      cmd_set_i = 1'b0; cmd_rekey_i = 1'b0; cmd_clr_i = 1'b0;
      tick(1);
      chk(!lock_o && !key_valid_o && erase_busy_o, "R8 commands ignored while clearing",
          {61'd0, lock_o, key_valid_o, erase_busy_o}, 1);
      chk(!sram_permit_o, "R11 permit denied while clearing", {63'd0, sram_permit_o}, 0);
      tick(80);
      sdi_i = 1'b1; tick(ACC + 3); sdi_i = 1'b0;

      wait_done("R7 clearing completes");
      chk(key_o == KB && key_valid_o, "R7 fresh key after fill", key_o, KB);
      chk(exp_q.size() == 0, "R6 all fill writes seen", exp_q.size(), 0);
      chk(kill_cnt == 0, "R8 tamper ignored while clearing", kill_cnt, 0);

      // R9 erase key fixes session key
      rnd_i = KC;
      cmd_rekey_i = 1'b1; tick(1); cmd_rekey_i = 1'b0; tick(1);
      chk(key_o == KB, "R9 erase key holds for session", key_o, KB);

      // R3 loader exit, then a new session
      prog_n_i = 1'b1;
      tick(QUAL + 1);
      chk(loader_o, "R3 loader still active", {63'd0, loader_o}, 1);
      tick(1);
      chk(!loader_o, "R3 loader left", {63'd0, loader_o}, 0);
      prog_n_i = 1'b0;
      tick(QUAL + 2);
      cmd_rekey_i = 1'b1; tick(1); cmd_rekey_i = 1'b0; tick(1);
      chk(key_o == KC, "R9 new session draws new key", key_o, KC);

      // R2 short tamper pulse
      kill_cnt = 0;
      sdi_i = 1'b1; tick(ACC - 1); sdi_i = 1'b0;
      tick(20);
      chk(key_o == KC && key_valid_o && !erase_busy_o && kill_cnt == 0,
          "R2 short pulse rejected", {31'd0, erase_busy_o, kill_cnt[31:0]}, 0);

      // R13 tamper with same-cycle engage command
      cmd_set_i = 1'b1; tick(1); cmd_set_i = 1'b0; tick(1);
      chk(lock_o, "R10 lock engaged again", {63'd0, lock_o}, 1);
      kill_cnt = 0;
      rnd_i = KD;
      push_erase();
      sdi_i = 1'b1;
      tick(ACC);
      sdi_i = 1'b0;
      tick(1);
      chk(!erase_busy_o && key_valid_o, "R2 tamper not yet started",
          {62'd0, erase_busy_o, key_valid_o}, 1);
      cmd_set_i = 1'b1;
      tick(1);
      cmd_set_i = 1'b0;
      chk(!lock_o, "R13 tamper wins over engage", {63'd0, lock_o}, 0);
      chk(!key_valid_o && key_o == 0, "R4 tamper clears key", key_o, 0);
      chk(bus_kill_o && vec_wr_o, "R2 tamper starts clearing", {62'd0, bus_kill_o, vec_wr_o}, 3);
      tick(KILL + 4);
      chk(kill_cnt == KILL, "R12 power kill length", kill_cnt, KILL);
      wait_done("R7 tamper clearing completes");
      chk(key_o == KD && key_valid_o, "R7 key after tamper clearing", key_o, KD);
      chk(exp_q.size() == 0, "R6 tamper fill complete", exp_q.size(), 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule